// File: doc/BRIEF.md
# FPGA Passive Configuration Sequencer

This block acts as the master that loads a configuration bitstream into a target FPGA over a passive link. A controller supplies a byte count and a link mode, then pulses `start`. The bitstream arrives as bytes on a valid/ready stream. The sequencer first holds the target's configuration-reset pin low. It then waits for the target to get ready and clocks the bytes out on the configuration clock and data pins. It finishes with one trailing clock, after which it checks the configuration-complete input.

Three link modes share one clocking engine:
- **Serial:** one bit per clock, least significant bit first.
- **Parallel:** one clock per byte on an 8-bit bus.
- **Secure parallel:** four clocks per byte.

Before each byte is accepted, the sequencer checks the target's status input. If that input is low, the load stops. Whether a load ends in success or failure, the result is held on `done`, or on `error` with a failure code and the number of bytes completed, until the next `start`. All delays and the clock half-period are parameters counted in system clock cycles.

Top module: `fpga_cfg_seq`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `ncfg_o` is high, `dclk_o` is low and `data_o` is zero. `busy`, `done`, `error` and `s_ready` are low out of reset.
- R2: A valid start drives `ncfg_o` low for exactly CFG_LOW_CYC cycles and then high again. The first rising edge of `dclk_o` comes at least CFG_WAIT_CYC cycles after `ncfg_o` returns high.
- R3: Each level of `dclk_o` is held for at least HALF_CYC cycles. `s_ready` is never high while `dclk_o` is high, so a new byte is taken only while the clock is low.
- R4: With `mode` = 0 (serial), each byte gives eight rising edges of `dclk_o`. At the k-th edge, `data_o[0]` equals bit k of the byte (bit 0 first) and `data_o[7:1]` is zero.
- R5: With `mode` = 1 (parallel), each byte gives exactly one rising edge of `dclk_o`, with the whole byte on `data_o` at that edge.
- R6: With `mode` = 2 (secure parallel), each byte gives four rising edges of `dclk_o`, with the same byte on `data_o` at all four.
- R7: After the last byte, one extra rising edge of `dclk_o` is issued. DONE_WAIT_CYC cycles later `confdone_i` is sampled. If it is high, `done` rises, `busy` falls, `dclk_o` returns low and `data_o` returns to zero. `done` then holds until the next start.
- R8: The status input `nstatus_i` is checked before every byte. If it is low while a byte is awaited, the load aborts with `fail_code` = 2 and `fail_count` = the number of bytes fully clocked. No further byte is accepted, even with `s_valid` high.
- R9: If `confdone_i` is low when it is sampled, the load aborts with `fail_code` = 3 and `fail_count` = `byte_total`.
- R10: A start with `byte_total` = 0 or `mode` = 3 is refused. `error` rises with `fail_code` = 1 and `fail_count` = 0, `busy` stays low, and `ncfg_o`, `dclk_o` and `data_o` show no activity.
- R11: Any abort leaves `ncfg_o` high, `dclk_o` low, `data_o` zero and `busy` low. `error` and `fail_code` then hold until the next start, and that start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load (ignored while busy) |
| mode | input | 2 | 0 serial, 1 parallel, 2 secure parallel, 3 refused |
| byte_total | input | CNT_W | Number of bitstream bytes to send |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high together with s_valid |
| ncfg_o | output | 1 | Target configuration-reset pin (active low) |
| dclk_o | output | 1 | Configuration clock to the target |
| data_o | output | 8 | Configuration data; bit 0 only in serial mode |
| nstatus_i | input | 1 | Target status, low means the target reports an error |
| confdone_i | input | 1 | Target configuration-complete flag |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed successfully |
| error | output | 1 | Last request or load failed |
| fail_code | output | 2 | 0 none, 1 refused request, 2 status low, 3 completion flag low |
| fail_count | output | CNT_W | Bytes fully clocked when the failure happened |

## Verification
The two functions that can fall in the same cycle are the status check and the stream handshake. The sequencer can be waiting for a byte while the source already offers one, and in that same cycle the target can pull its status input low. The bench provokes this by dropping `nstatus_i` just after the second byte's capture edge while the source keeps `s_valid` high with the third byte. It then judges that the abort wins: exactly two handshakes occur, exactly two capture edges are seen, `fail_count` reads 2, and all pins are idle afterwards.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

  typedef enum logic [1:0] {
    LINK_SER = 2'd0,
    LINK_PAR = 2'd1,
    LINK_SEC = 2'd2,
    LINK_BAD = 2'd3
  } link_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_REQ    = 2'd1,
    FC_STATUS = 2'd2,
    FC_CONF   = 2'd3
  } fcode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RST_LO,
    SQ_SETUP,
    SQ_FETCH,
    SQ_LOW,
    SQ_HIGH,
    SQ_TAIL_LO,
    SQ_CONF_WAIT
  } seq_e;

  // a link code the engine knows how to clock
  function automatic logic link_ok(input logic [1:0] m);
    return m != LINK_BAD;
  endfunction

  // rising clock edges spent on one byte
  function automatic logic [3:0] pulses_per_byte(input logic [1:0] m);
    case (m)
      LINK_SER: return 4'd8;
      LINK_PAR: return 4'd1;
      LINK_SEC: return 4'd4;
      default:  return 4'd0;
    endcase
  endfunction

  // value presented on the data pins for the current pulse
  function automatic logic [7:0] lane_value(input logic [1:0] m, input logic [7:0] b);
    if (m == LINK_SER) return {7'b0, b[0]};
    return b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned r;
    r = (a > b) ? a : b;
    return (r > c) ? r : c;
  endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  // a load of N makes expired true in the N-th cycle after the load edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import fpga_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       step,
  input  logic       clear,
  input  logic [1:0] mode,
  input  logic [7:0] din,
  output logic [7:0] lane,
  output logic       last_pulse
);

  logic [7:0] byte_q;
  logic [3:0] left_q;
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      left_q <= '0;
      mode_q <= LINK_PAR;
    end else if (clear) begin
      byte_q <= '0;
      left_q <= '0;
    end else if (take) begin
      byte_q <= din;
      left_q <= pulses_per_byte(mode);
      mode_q <= mode;
    end else if (step && left_q != '0) begin
      left_q <= left_q - 4'd1;
      if (mode_q == LINK_SER) byte_q <= byte_q >> 1;
    end
  end

  assign lane       = lane_value(mode_q, byte_q);
  assign last_pulse = (left_q == 4'd1);

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int CNT_W         = 24,
  parameter int CFG_LOW_CYC   = 1000,
  parameter int CFG_WAIT_CYC  = 20000,
  parameter int HALF_CYC      = 4,
  parameter int DONE_WAIT_CYC = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] byte_total,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             ncfg_o,
  output logic             dclk_o,
  output logic [7:0]       data_o,
  input  logic             nstatus_i,
  input  logic             confdone_i,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [1:0]       fail_code,
  output logic [CNT_W-1:0] fail_count
);

  localparam int unsigned MAX_WAIT =
    max3(CFG_LOW_CYC, CFG_WAIT_CYC, (DONE_WAIT_CYC > HALF_CYC) ? DONE_WAIT_CYC : HALF_CYC);
  localparam int TW = $clog2(MAX_WAIT + 1) + 1;

  seq_e             st_q;
  logic             ncfg_q, dclk_q, busy_q, done_q, err_q;
  logic [1:0]       code_q;
  logic [CNT_W-1:0] sent_q, total_q, fcnt_q;

  // named internal events, also seen by the checker
  logic             req_ok, t_load, t_exp;
  logic [TW-1:0]    t_len;
  logic             byte_take, status_abort, rise_ev, fall_ev;
  logic             byte_end, final_byte, conf_ok, conf_bad, lane_clear;
  logic             last_pulse;
  logic [7:0]       lane;
  logic [CNT_W-1:0] sent_next;

  assign req_ok       = (byte_total != '0) && link_ok(mode);
  assign s_ready      = (st_q == SQ_FETCH) && nstatus_i;
  assign byte_take    = s_valid && s_ready;
  assign status_abort = (st_q == SQ_FETCH) && !nstatus_i;
  assign rise_ev      = ((st_q == SQ_LOW) || (st_q == SQ_TAIL_LO)) && t_exp;
  assign fall_ev      = (st_q == SQ_HIGH) && t_exp;
  assign byte_end     = fall_ev && last_pulse;
  assign sent_next    = sent_q + CNT_W'(1);
  assign final_byte   = byte_end && (sent_next == total_q);
  assign conf_ok      = (st_q == SQ_CONF_WAIT) && t_exp && confdone_i;
  assign conf_bad     = (st_q == SQ_CONF_WAIT) && t_exp && !confdone_i;
  assign lane_clear   = status_abort || conf_ok || conf_bad;

  // timer reload selection
  always_comb begin
    t_load = 1'b0;
    t_len  = TW'(HALF_CYC);
    unique case (st_q)
      SQ_IDLE: if (start && req_ok) begin
        t_load = 1'b1;
        t_len  = TW'(CFG_LOW_CYC);
      end
      SQ_RST_LO: if (t_exp) begin
        t_load = 1'b1;
        t_len  = TW'(CFG_WAIT_CYC);
      end
      SQ_FETCH:   t_load = byte_take;
      SQ_LOW:     t_load = t_exp;
      SQ_HIGH:    t_load = t_exp;
      SQ_TAIL_LO: if (t_exp) begin
        t_load = 1'b1;
        t_len  = TW'(DONE_WAIT_CYC);
      end
      default: ;
    endcase
  end

  cfg_wait_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .len     (t_len),
    .expired (t_exp)
  );

  cfg_lane_unit u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (byte_take),
    .step       (fall_ev),
    .clear      (lane_clear),
    .mode       (mode),
    .din        (s_data),
    .lane       (lane),
    .last_pulse (last_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      ncfg_q  <= 1'b1;
      dclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= FC_NONE;
      sent_q  <= '0;
      total_q <= '0;
      fcnt_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          done_q <= 1'b0;
          fcnt_q <= '0;
          if (req_ok) begin
            busy_q  <= 1'b1;
            ncfg_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= FC_NONE;
            sent_q  <= '0;
            total_q <= byte_total;
            st_q    <= SQ_RST_LO;
          end else begin
            err_q  <= 1'b1;
            code_q <= FC_REQ;
          end
        end
        SQ_RST_LO: if (t_exp) begin
          ncfg_q <= 1'b1;
          st_q   <= SQ_SETUP;
        end
        SQ_SETUP: if (t_exp) st_q <= SQ_FETCH;
        SQ_FETCH: begin
          if (status_abort) begin
            ncfg_q <= 1'b1;
            dclk_q <= 1'b0;
            busy_q <= 1'b0;
            err_q  <= 1'b1;
            code_q <= FC_STATUS;
            fcnt_q <= sent_q;
            st_q   <= SQ_IDLE;
          end else if (byte_take) begin
            st_q <= SQ_LOW;
          end
        end
        SQ_LOW: if (t_exp) begin
          dclk_q <= 1'b1;
          st_q   <= SQ_HIGH;
        end
        SQ_HIGH: if (t_exp) begin
          dclk_q <= 1'b0;
          if (byte_end) begin
            sent_q <= sent_next;
            st_q   <= final_byte ? SQ_TAIL_LO : SQ_FETCH;
          end else begin
            st_q <= SQ_LOW;
          end
        end
        SQ_TAIL_LO: if (t_exp) begin
          dclk_q <= 1'b1;
          st_q   <= SQ_CONF_WAIT;
        end
        SQ_CONF_WAIT: if (t_exp) begin
          dclk_q <= 1'b0;
          ncfg_q <= 1'b1;
          busy_q <= 1'b0;
          st_q   <= SQ_IDLE;
          if (confdone_i) begin
            done_q <= 1'b1;
          end else begin
            err_q  <= 1'b1;
            code_q <= FC_CONF;
            fcnt_q <= sent_q;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ncfg_o     = ncfg_q;
  assign dclk_o     = dclk_q;
  assign data_o     = busy_q ? lane : 8'h00;
  assign busy       = busy_q;
  assign done       = done_q;
  assign error      = err_q;
  assign fail_code  = code_q;
  assign fail_count = fcnt_q;

endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk #(
  parameter int HALF_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       s_ready,
  input logic       byte_take,
  input logic       rise_ev,
  input logic       dclk_o,
  input logic       ncfg_o,
  input logic [7:0] data_o,
  input logic       busy,
  input logic       done,
  input logic       error
);

  localparam int HW = $clog2(HALF_CYC + 1) + 1;

  logic          prev_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= HW'(HALF_CYC);
    end else begin
      prev_q <= dclk_o;
      if (dclk_o != prev_q)               hold_q <= HW'(1);
      else if (hold_q < HW'(HALF_CYC))    hold_q <= hold_q + HW'(1);
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ncfg_o && !dclk_o && data_o == 8'h00));

  // R2
  reset_pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ncfg_o) |-> busy);

  // R3
  dclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o != prev_q) |-> (hold_q >= HW'(HALF_CYC)));

  // R3
  ready_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !dclk_o);

  // R3
  take_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> !dclk_o);

  // R4
  rise_while_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> (dclk_o && ncfg_o && busy));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  // R11
  abort_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (ncfg_o && !dclk_o && data_o == 8'h00 && !busy));

endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .s_ready   (s_ready),
  .byte_take (byte_take),
  .rise_ev   (rise_ev),
  .dclk_o    (dclk_o),
  .ncfg_o    (ncfg_o),
  .data_o    (data_o),
  .busy      (busy),
  .done      (done),
  .error     (error)
);

// File: tb/sim_fpga_cfg_seq.sv
`timescale 1ns/1ps
module sim_fpga_cfg_seq;

  localparam int CNT_W = 16;
  localparam int LOW_C = 5;
  localparam int WAIT_C = 10;
  localparam int HALF_C = 2;
  localparam int DONE_C = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [CNT_W-1:0] byte_total = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, ncfg_o, dclk_o, busy, done, error;
  logic [7:0] data_o;
  logic nstatus_i = 1'b1;
  logic confdone_i = 1'b1;
  logic [1:0] fail_code;
  logic [CNT_W-1:0] fail_count;

  always #2.5 clk = ~clk;

  fpga_cfg_seq #(
    .CNT_W(CNT_W), .CFG_LOW_CYC(LOW_C), .CFG_WAIT_CYC(WAIT_C),
    .HALF_CYC(HALF_C), .DONE_WAIT_CYC(DONE_C)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .byte_total(byte_total),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .ncfg_o(ncfg_o), .dclk_o(dclk_o), .data_o(data_o),
    .nstatus_i(nstatus_i), .confdone_i(confdone_i),
    .busy(busy), .done(done), .error(error),
    .fail_code(fail_code), .fail_count(fail_count)
  );

  int n_tests = 0;
  int n_fail = 0;

  // stream source and pin monitor state
  logic [7:0] tx_mem [0:15];
  int tx_n = 0, idx = 0;
  logic src_en = 1'b0, src_gap = 1'b0, fire_pend = 1'b0;
  logic [7:0] cap [0:127];
  int cap_n = 0, cyc = 0;
  logic prev_dclk = 1'b0, prev_ncfg = 1'b1;
  int lo_run = 0, lo_width = 0, ncfg_rise_cyc = -1, first_rise_cyc = -1;
  int ncfg_low_samples = 0;
  int hold_run = 100, hold_viol = 0, rdy_hi_viol = 0;
  int drop_after = -1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // monitor
      if (dclk_o && !prev_dclk) begin
        if (cap_n < 128) cap[cap_n] = data_o;
        cap_n++;
        if (first_rise_cyc < 0) first_rise_cyc = cyc;
        if (cap_n == drop_after) nstatus_i = 1'b0;
      end
      if (dclk_o != prev_dclk) begin
        if (hold_run < HALF_C) hold_viol++;
        hold_run = 1;
      end else hold_run++;
      if (s_ready && dclk_o) rdy_hi_viol++;
      if (!ncfg_o) begin
        lo_run++;
        ncfg_low_samples++;
      end
      if (ncfg_o && !prev_ncfg) begin
        lo_width = lo_run;
        ncfg_rise_cyc = cyc;
      end
      if (ncfg_o) lo_run = 0;
      prev_dclk = dclk_o;
      prev_ncfg = ncfg_o;
      // driver
      if (fire_pend) idx++;
      s_valid = src_en && (idx < tx_n) && !(src_gap && cyc[0]);
      s_data  = (idx < 16) ? tx_mem[idx] : 8'h00;
      fire_pend = s_valid && s_ready;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    n_tests++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
    end
  endtask

  task automatic kick(input logic [1:0] m, input int n);
    tick();
    cap_n = 0; idx = 0; fire_pend = 1'b0; first_rise_cyc = -1;
    ncfg_rise_cyc = -1; lo_width = 0; ncfg_low_samples = 0;
    tx_n = n;
    start = 1'b1; mode = m; byte_total = CNT_W'(n);
    tick();
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) tick();
  endtask

  function automatic int ppb(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 1 : 4;
  endfunction

  function automatic logic [7:0] exp_cap(input logic [1:0] m, input int k);
    if (m == 2'd0) return {7'b0, tx_mem[k / 8][k % 8]};
    return tx_mem[k / ppb(m)];
  endfunction

  task automatic t_reset();
    chk_eq("R1 ncfg", ncfg_o, 1);
    chk_eq("R1 dclk/data", {dclk_o, data_o}, 0);
    chk_eq("R1 flags", {busy, done, error, s_ready}, 0);
  endtask

  task automatic t_refuse(input logic [1:0] m, input int n, input string tag);
    kick(m, n);
    chk_eq({"R10 error ", tag}, error, 1);
    chk_eq({"R10 code ", tag}, fail_code, 1);
    chk_eq({"R10 count ", tag}, fail_count, 0);
    repeat (20) tick();
    chk_eq({"R10 quiet ", tag}, ncfg_low_samples + cap_n + busy, 0);
  endtask

  task automatic t_load(input logic [1:0] m, input int n, input logic [7:0] base,
                        input string tag);
    int bad;
    for (int i = 0; i < n; i++) tx_mem[i] = base + 8'(i * 37);
    confdone_i = 1'b1; src_en = 1'b1;
    kick(m, n);
    chk_eq({"R11 cleared ", tag}, error, 0);
    wait_idle();
    tick();
    chk_eq({"R2 ncfg low width ", tag}, lo_width, LOW_C);
    chk_ge({"R2 setup wait ", tag}, first_rise_cyc - ncfg_rise_cyc, WAIT_C);
    bad = 0;
    for (int k = 0; k < n * ppb(m); k++) if (cap[k] != exp_cap(m, k)) bad++;
    if (m == 2'd0)      chk_eq({"R4 serial bits ", tag}, bad, 0);
    else if (m == 2'd1) chk_eq({"R5 parallel bytes ", tag}, bad, 0);
    else                chk_eq({"R6 secure bytes ", tag}, bad, 0);
    chk_eq({"R7 rise count ", tag}, cap_n, n * ppb(m) + 1);
    chk_eq({"R7 done ", tag}, {done, busy, error}, 3'b100);
    chk_eq({"R7 pins idle ", tag}, {ncfg_o, dclk_o, data_o}, 10'h200);
    chk_eq({"R3 hold/ready ", tag}, hold_viol + rdy_hi_viol, 0);
    src_en = 1'b0;
  endtask

  task automatic t_status_drop();
    for (int i = 0; i < 4; i++) tx_mem[i] = 8'h90 + 8'(i);
    src_en = 1'b1; drop_after = 2;
    kick(2'd1, 4);
    wait_idle();
    tick();
    chk_eq("R8 code", fail_code, 2);
    chk_eq("R8 count", fail_count, 2);
    chk_eq("R8 accepted", idx, 2);
    chk_eq("R8 rises", cap_n, 2);
    chk_eq("R8 valid still offered", s_valid, 1);
    chk_eq("R11 pins after abort", {ncfg_o, dclk_o, data_o, busy}, 11'h400);
    repeat (30) tick();
    chk_eq("R11 error held", {error, fail_code}, 3'b110);
    nstatus_i = 1'b1; drop_after = -1; src_en = 1'b0;
  endtask

  task automatic t_conf_low();
    tx_mem[0] = 8'h6B; src_en = 1'b1; confdone_i = 1'b0;
    kick(2'd0, 1);
    wait_idle();
    tick();
    chk_eq("R9 code", fail_code, 3);
    chk_eq("R9 count", fail_count, 1);
    chk_eq("R9 flags", {done, error, busy}, 3'b010);
    confdone_i = 1'b1; src_en = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_refuse(2'd1, 0, "zero count");
    t_refuse(2'd3, 4, "bad mode");
    t_load(2'd0, 2, 8'hA5, "serial");
    t_load(2'd1, 3, 8'h3C, "parallel");
    src_gap = 1'b1;
    t_load(2'd2, 2, 8'hE1, "secure gap");
    src_gap = 1'b0;
    t_status_drop();
    t_load(2'd1, 1, 8'h0F, "after abort");
    t_conf_low();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule